// File: doc/BRIEF.md
# Periodic Interrupt Timer with Priority Arbitration

This block produces a periodic interrupt. A down-counter advances on each cycle in which the tick enable input is high. When it expires, it reloads from a period register and records a pending timer request. That request carries a programmable priority level (1 to 7) and a programmable 8-bit vector. Software programs three values through a single write port: the period, the level and the vector. The processor's acknowledge clears the pending timer request.

The block also arbitrates the timer request against one external request line that has its own level and vector. The higher level wins. On equal levels the timer wins. A winner is presented only if its level exceeds the processor's current mask, except level 7, which is never masked.

A level of zero silences the request while the counter keeps its rhythm. A period of zero halts the counter outright. The block has no stop-mode input, so the count is never paused by a processor low-power state.

Top module: `pit_core`

## Requirements
- R1: After reset no request is presented (`irq_valid`=0, `irq_lvl`=0, `irq_vec`=0, `irq_src`=0). The period resets to 0 (counter halted), the level to 0, and the vector to 8'h0F.
- R2: From a halted counter (count 0) with a nonzero period P, the first tick loads P. After that, expiry happens on every P-th tick: the tick taken while the count is 1 reloads P.
- R3: An expiry with a nonzero level sets the timer request pending. One clock edge later the outputs show `irq_valid`=1, `irq_src`=1, and the current level and vector.
- R4: A pending timer request stays pending until `ack` is high in a cycle where the outputs present it (`irq_valid`=1, `irq_src`=1). Expiries while it is pending do not queue, so one acknowledge clears it. An `ack` while an external request is presented leaves the timer request pending.
- R5: With level 0, expiries raise no request, but the counter keeps counting and reloading.
- R6: A nonzero period write does not disturb the count in progress. The new value is first used at the next reload.
- R7: While the period is 0, the count is forced to 0 and no expiry occurs. A later nonzero period restarts counting as in R2.
- R8: Write select codes: 0 = period (`wr_data` full width), 1 = level (`wr_data[2:0]`), 2 = vector (`wr_data[7:0]`). Code 3 changes nothing.
- R9: Between the pending timer request and the external request, the higher level wins. If the levels are equal, the timer wins (`irq_src`=1). External level 0 means no external request.
- R10: The winner is presented only if its level is 7 or strictly above `cpu_mask`. The outputs are registered, one edge after the inputs. When nothing is presented, level, vector and source read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 period, 1 level, 2 vector) |
| wr_data | input | CNT_W | Write data |
| ext_lvl | input | 3 | External request level, 0 = none |
| ext_vec | input | VEC_W | External request vector |
| cpu_mask | input | 3 | Processor interrupt mask |
| ack | input | 1 | Acknowledge of the presented request |
| irq_valid | output | 1 | Request presented |
| irq_lvl | output | 3 | Level of presented request |
| irq_vec | output | VEC_W | Vector of presented request |
| irq_src | output | 1 | 1 = timer, 0 = external |

## Verification
The assertions assume that `ext_lvl`, `ext_vec`, `cpu_mask` and `ack` are synchronous to `clk`. They also assume that `ack` is a single-cycle pulse given only while a request is shown. The stimulus changes every input on the falling edge, and it raises `ack` for exactly one cycle while the outputs present a request. The arbitration table keeps the timer request pending at a fixed level and vector and varies only the external line and the mask, so each row tests a single comparison.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_NONE = '0;
  localparam logic [LVL_W-1:0] LVL_NMI  = '1;

  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_LEVEL  = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_SPARE  = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] period_q,
  output logic [LVL_W-1:0] level_q,
  output logic [VEC_W-1:0] vector_q
);
  wr_sel_e sel;
  assign sel = wr_sel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      level_q  <= LVL_NONE;
      vector_q <= VEC_RST;
    end else if (wr_en) begin
      case (sel)
        SEL_PERIOD: period_q <= wr_data;
        SEL_LEVEL:  level_q  <= wr_data[LVL_W-1:0];
        SEL_VECTOR: vector_q <= wr_data[VEC_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic halted;
  logic at_load;

  assign halted  = (period == '0);
  assign at_load = (count == '0) || (count == ONE);
  assign expire  = tick && !halted && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (halted) begin
      count <= '0;
    end else if (tick) begin
      if (at_load) count <= period;
      else         count <= count - ONE;
    end
  end
endmodule

// File: rtl/pit_arbiter.sv
module pit_arbiter
  import pit_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] t_lvl,
  input  logic [VEC_W-1:0] t_vec,
  input  logic [LVL_W-1:0] e_lvl,
  input  logic [VEC_W-1:0] e_vec,
  input  logic [LVL_W-1:0] mask,
  output logic             irq_valid,
  output logic [LVL_W-1:0] irq_lvl,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_src
);
  logic             t_win;
  logic [LVL_W-1:0] w_lvl;
  logic [VEC_W-1:0] w_vec;
  logic             present;

  always_comb begin
    t_win   = (t_lvl != LVL_NONE) && (t_lvl >= e_lvl);
    w_lvl   = t_win ? t_lvl : e_lvl;
    w_vec   = t_win ? t_vec : e_vec;
    present = (w_lvl != LVL_NONE) && ((w_lvl == LVL_NMI) || (w_lvl > mask));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_lvl   <= LVL_NONE;
      irq_vec   <= '0;
      irq_src   <= 1'b0;
    end else begin
      irq_valid <= present;
      irq_lvl   <= present ? w_lvl : LVL_NONE;
      irq_vec   <= present ? w_vec : '0;
      irq_src   <= present && t_win;
    end
  end
endmodule

// File: rtl/pit_core.sv
module pit_core
  import pit_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       ext_lvl,
  input  logic [VEC_W-1:0] ext_vec,
  input  logic [2:0]       cpu_mask,
  input  logic             ack,
  output logic             irq_valid,
  output logic [2:0]       irq_lvl,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_src
);
  logic [CNT_W-1:0] period_q;
  logic [LVL_W-1:0] level_q;
  logic [VEC_W-1:0] vector_q;
  logic [CNT_W-1:0] count;
  logic             expire;
  logic             pend_q;
  logic             pend_clr;
  logic             pend_set;
  logic [LVL_W-1:0] t_lvl;

  pit_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W), .VEC_RST(VEC_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .period_q(period_q), .level_q(level_q), .vector_q(vector_q)
  );

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .period(period_q),
    .count(count), .expire(expire)
  );

  assign pend_set = expire && (level_q != LVL_NONE);
  assign pend_clr = ack && irq_valid && irq_src;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (pend_q && !pend_clr) || pend_set;
  end

  assign t_lvl = pend_q ? level_q : LVL_NONE;

  pit_arbiter #(.VEC_W(VEC_W)) u_arb (
    .clk(clk), .rst(rst), .t_lvl(t_lvl), .t_vec(vector_q),
    .e_lvl(ext_lvl), .e_vec(ext_vec), .mask(cpu_mask),
    .irq_valid(irq_valid), .irq_lvl(irq_lvl), .irq_vec(irq_vec), .irq_src(irq_src)
  );
endmodule

// File: rtl/pit_chk.sv
module pit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ack,
  input logic [2:0]       ext_lvl,
  input logic [2:0]       cpu_mask,
  input logic             irq_valid,
  input logic [2:0]       irq_lvl,
  input logic             irq_src,
  input logic [CNT_W-1:0] period_q,
  input logic             expire,
  input logic             pend_q
);
  assert_lvl_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_lvl != 3'd0));

  assert_mask_R10: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> ((irq_lvl == 3'd7) || (irq_lvl > $past(cpu_mask))));

  assert_halted_R7: assert property (@(posedge clk) disable iff (rst)
    (period_q == '0) |-> !expire);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !(ack && irq_valid && irq_src)) |=> pend_q);

  assert_ext_level_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_src) |-> (irq_lvl == $past(ext_lvl)));

  assert_timer_beats_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_src) |-> (irq_lvl >= $past(ext_lvl)));
endmodule

bind pit_core pit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .ext_lvl(ext_lvl), .cpu_mask(cpu_mask),
  .irq_valid(irq_valid), .irq_lvl(irq_lvl), .irq_src(irq_src),
  .period_q(period_q), .expire(expire), .pend_q(pend_q)
);

// File: tb/tb_pit_core.sv
module tb_pit_core;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int VEC_W = 8;
  localparam int NROWS = 10;

  // row: ext_lvl, ext_vec, mask | valid, lvl, vec, src
  localparam logic [26:0] ROWS [NROWS] = '{
    {3'd0, 8'h00, 3'd0, 1'b1, 3'd4, 8'hA5, 1'b1},
    {3'd4, 8'h11, 3'd0, 1'b1, 3'd4, 8'hA5, 1'b1},
    {3'd5, 8'h22, 3'd0, 1'b1, 3'd5, 8'h22, 1'b0},
    {3'd3, 8'h33, 3'd0, 1'b1, 3'd4, 8'hA5, 1'b1},
    {3'd0, 8'h00, 3'd4, 1'b0, 3'd0, 8'h00, 1'b0},
    {3'd0, 8'h00, 3'd3, 1'b1, 3'd4, 8'hA5, 1'b1},
    {3'd6, 8'h44, 3'd5, 1'b1, 3'd6, 8'h44, 1'b0},
    {3'd5, 8'h55, 3'd5, 1'b0, 3'd0, 8'h00, 1'b0},
    {3'd7, 8'h66, 3'd7, 1'b1, 3'd7, 8'h66, 1'b0},
    {3'd7, 8'h77, 3'd6, 1'b1, 3'd7, 8'h77, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [2:0] ext_lvl = 3'd0;
  logic [VEC_W-1:0] ext_vec = '0;
  logic [2:0] cpu_mask = 3'd0;
  logic ack = 1'b0;
  logic irq_valid;
  logic [2:0] irq_lvl;
  logic [VEC_W-1:0] irq_vec;
  logic irq_src;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_core #(.CNT_W(CNT_W), .VEC_W(VEC_W)) dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ext_lvl(ext_lvl), .ext_vec(ext_vec),
    .cpu_mask(cpu_mask), .ack(ack), .irq_valid(irq_valid),
    .irq_lvl(irq_lvl), .irq_vec(irq_vec), .irq_src(irq_src)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [CNT_W-1:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    step(n);
    tick = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    check("R1 valid", irq_valid, 0);
    check("R1 lvl", irq_lvl, 0);
    check("R1 src", irq_src, 0);

    wr(2'd0, 16'd3);
    wr(2'd1, 16'd3);
    ticks(3);
    check("R2 early", irq_valid, 0);
    ticks(1);
    check("R3 registered", irq_valid, 0);
    step(1);
    check("R3 valid", irq_valid, 1);
    check("R3 lvl", irq_lvl, 3);
    check("R1 vector reset", irq_vec, 8'h0F);
    check("R3 src", irq_src, 1);

    ticks(3);
    pulse_ack();
    check("R4 no queue", irq_valid, 0);

    wr(2'd1, 16'd0);
    ticks(2);
    wr(2'd1, 16'd4);
    ticks(1);
    step(1);
    check("R5 counter ran", irq_valid, 1);
    check("R5 lvl", irq_lvl, 4);
    pulse_ack();

    wr(2'd0, 16'd5);
    ticks(3);
    step(1);
    check("R6 old count", irq_valid, 1);
    pulse_ack();
    ticks(4);
    step(1);
    check("R6 new period early", irq_valid, 0);
    ticks(1);
    step(1);
    check("R6 new period", irq_valid, 1);
    pulse_ack();

    ticks(2);
    wr(2'd0, 16'd0);
    ticks(10);
    step(1);
    check("R7 halted", irq_valid, 0);
    wr(2'd0, 16'd2);
    ticks(2);
    step(1);
    check("R7 restart early", irq_valid, 0);
    ticks(1);
    step(1);
    check("R7 restart", irq_valid, 1);
    pulse_ack();

    wr(2'd3, 16'hFFFF);
    ticks(2);
    step(1);
    check("R8 spare lvl", irq_lvl, 4);
    check("R8 spare vec", irq_vec, 8'h0F);
    pulse_ack();
    wr(2'd2, 16'h12A5);
    ticks(2);
    step(1);
    check("R8 vector", irq_vec, 8'hA5);

    for (int i = 0; i < NROWS; i++) begin
      ext_lvl  = ROWS[i][26:24];
      ext_vec  = ROWS[i][23:16];
      cpu_mask = ROWS[i][15:13];
      step(1);
      check($sformatf("R9/R10 row%0d valid", i), irq_valid, ROWS[i][12]);
      check($sformatf("R9/R10 row%0d lvl", i), irq_lvl, ROWS[i][11:9]);
      check($sformatf("R9/R10 row%0d vec", i), irq_vec, ROWS[i][8:1]);
      check($sformatf("R9/R10 row%0d src", i), irq_src, ROWS[i][0]);
    end

    ext_lvl = 3'd0; cpu_mask = 3'd7;
    wr(2'd1, 16'd7);
    step(1);
    check("R10 nmi valid", irq_valid, 1);
    check("R10 nmi lvl", irq_lvl, 7);

    cpu_mask = 3'd0;
    wr(2'd1, 16'd2);
    ext_lvl = 3'd6; ext_vec = 8'h3C;
    step(1);
    check("R4 ext shown", irq_src, 0);
    pulse_ack();
    ext_lvl = 3'd0;
    step(1);
    check("R4 timer kept", irq_valid, 1);
    check("R4 timer lvl", irq_lvl, 2);
    check("R4 timer src", irq_src, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule